// File: doc/BRIEF.md
# Predicated Vector Branch Condition Step Evaluator

This block decides, for one element of a vectorised conditional branch, whether the branch condition holds. It also works out how the loop count register changes and whether the vector length is cut short. It also produces the link-register and vector-link-register write enables. One element is evaluated per valid strobe. All results appear in registers on the following clock edge, flagged by an output-valid bit.

The element's predicate bit steers the evaluation. A set predicate tests a selected bit of the 32-bit condition register. A clear predicate tests a substitute mode bit instead. If the mask-evaluate mode is also off, a clear predicate ends the element early. The count test honours a 32-bit or 64-bit operating width. Counter-test and inversion modes change when the count is decremented. A truncation mode rewrites the vector length when the combined test result matches a chosen sense. Branch target fetch, address generation and program-counter update sit outside this block.

Top module: `vbr_step_eval`

## Requirements
- R1: While rst_n is low, out_valid, cnt_o, cond_met, vl_we, vl_val, lr_we, svlr_we and early_done are all zero.
- R2: Results of a step strobed by in_valid appear exactly one clock later with out_valid high. out_valid is low one clock after a cycle without in_valid.
- R3: The tested bit is cond_reg[31-crsel] when pred is 1, and m_subst when pred is 0 (crsel counts from the most significant bit).
- R4: The count check passes when br_ctl[2] is 1, or when (count nonzero) XOR br_ctl[3] is 1. The count is judged on all 64 bits when wide_mode is 1 and on bits 31:0 only when wide_mode is 0.
- R5: The condition check passes when br_ctl[0] is 1 or the tested bit equals br_ctl[1]. cond_met is high when both checks pass and the step is not an early finish.
- R6: When pred is 0 and m_mask_eval is 0, early_done is 1 and cond_met, vl_we, lr_we and svlr_we are 0. The count is decremented only if br_ctl[2] is 0, m_ctr_test is 1 and m_ctr_inv is 0.
- R7: In every other step the count is decremented when br_ctl[2] is 0 and NOT (m_ctr_test AND (condition check XOR m_ctr_inv)). The zero test uses the pre-decrement value, and decrementing zero wraps to all ones.
- R8: When the step is not an early finish, vl_we is 1 exactly when m_vl_trunc is 1 and m_vl_sense equals (count check AND condition check). The value written is srcstep+1 when m_vl_incl is 1 and srcstep otherwise.
- R9: vl_val never exceeds the vlen presented with the step; a larger candidate is replaced by vlen.
- R10: lr_we equals m_link and svlr_we equals m_vlink, each gated by both checks passing and the step not being an early finish.
- R11: In a cycle without in_valid every result register except out_valid holds its value, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Step strobe |
| br_ctl | input | 4 | Branch options: bit0 ignore condition, bit1 condition sense, bit2 ignore count, bit3 count-zero sense |
| crsel | input | 5 | Condition bit selector, numbered from the MSB |
| cond_reg | input | 32 | Condition register |
| cnt_i | input | 64 | Count register before the step |
| wide_mode | input | 1 | 1: 64-bit count test, 0: 32-bit |
| pred | input | 1 | Element predicate bit |
| m_mask_eval | input | 1 | Evaluate masked elements instead of finishing early |
| m_subst | input | 1 | Bit tested when pred is 0 |
| m_ctr_test | input | 1 | Counter-test mode |
| m_ctr_inv | input | 1 | Counter-test inversion |
| m_vl_trunc | input | 1 | Vector-length truncation enable |
| m_vl_sense | input | 1 | Test result that triggers truncation |
| m_vl_incl | input | 1 | Truncate to srcstep+1 instead of srcstep |
| m_vlink | input | 1 | Request vector-link update |
| m_link | input | 1 | Request link update |
| srcstep | input | 7 | Current element step |
| vlen | input | 7 | Current vector length |
| out_valid | output | 1 | Results valid |
| cnt_o | output | 64 | Count register after the step |
| cond_met | output | 1 | Branch condition met |
| vl_we | output | 1 | Vector-length write enable |
| vl_val | output | 7 | Vector-length value |
| lr_we | output | 1 | Link-register update enable |
| svlr_we | output | 1 | Vector-link-register update enable |
| early_done | output | 1 | Element finished early on a clear predicate |

## Verification
Random steps cover every option and mode combination, with counts drawn from zero, one, a value whose only set bit is bit 32, and wide random values. These counts separate the 32-bit and 64-bit zero tests and expose wrap-around on decrement. Directed steps exercise the early-finish path with each counter-test setting, which tells the two decrement rules apart. Other directed steps clamp a truncated length at vlen and move inputs while the strobe is low, which shows whether the result registers hold. Predicate-clear steps with a differing selected condition bit show whether the substitute bit, not the register bit, decides the outcome.

// File: rtl/vbr_pkg.sv
package vbr_pkg;
  typedef struct packed {
    logic mask_eval;
    logic subst;
    logic ctr_test;
    logic ctr_inv;
    logic vl_trunc;
    logic vl_sense;
    logic vl_incl;
    logic vlink;
    logic link;
  } vbr_mode_t;
endpackage

// File: rtl/vbr_cond_eval.sv
module vbr_cond_eval #(
  parameter int CNT_W = 64,
  parameter int CR_W  = 32,
  localparam int SEL_W = $clog2(CR_W),
  localparam int HALF  = CNT_W / 2
) (
  input  logic [3:0]       br_ctl,
  input  logic [SEL_W-1:0] crsel,
  input  logic [CR_W-1:0]  cond_reg,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wide_mode,
  input  logic             pred,
  input  logic             subst_bit,
  output logic             ctr_ok,
  output logic             cond_ok
);
  logic [SEL_W-1:0] cr_idx;
  logic             lo_nz, hi_nz, cnt_nz, test_bit;

  // MSB-first numbering of the selector
  assign cr_idx   = SEL_W'(CR_W - 1) - crsel;
  assign test_bit = pred ? cond_reg[cr_idx] : subst_bit;

  assign lo_nz  = |cnt[HALF-1:0];
  assign hi_nz  = |cnt[CNT_W-1:HALF];
  assign cnt_nz = lo_nz | (wide_mode & hi_nz);

  assign ctr_ok  = br_ctl[2] | (cnt_nz ^ br_ctl[3]);
  assign cond_ok = br_ctl[0] | (test_bit == br_ctl[1]);
endmodule

// File: rtl/vbr_cnt_update.sv
module vbr_cnt_update #(
  parameter int CNT_W = 64
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             ign_ctr,
  input  logic             early,
  input  logic             ctr_test,
  input  logic             ctr_inv,
  input  logic             cond_ok,
  output logic [CNT_W-1:0] cnt_nxt
);
  logic dec;

  always_comb begin
    if (early) dec = ~ign_ctr & ctr_test & ~ctr_inv;
    else       dec = ~ign_ctr & ~(ctr_test & (cond_ok ^ ctr_inv));
    cnt_nxt = dec ? (cnt - CNT_W'(1)) : cnt;
  end
endmodule

// File: rtl/vbr_vl_link.sv
module vbr_vl_link #(
  parameter int STEP_W = 7
) (
  input  logic              early,
  input  logic              ctr_ok,
  input  logic              cond_ok,
  input  logic              vl_trunc,
  input  logic              vl_sense,
  input  logic              vl_incl,
  input  logic              vlink,
  input  logic              link,
  input  logic [STEP_W-1:0] srcstep,
  input  logic [STEP_W-1:0] vlen,
  output logic              cond_met,
  output logic              vl_we,
  output logic [STEP_W-1:0] vl_val,
  output logic              lr_we,
  output logic              svlr_we
);
  logic            pass;
  logic [STEP_W:0] cand;

  assign pass     = ctr_ok & cond_ok;
  assign cond_met = pass & ~early;
  assign lr_we    = link  & pass & ~early;
  assign svlr_we  = vlink & pass & ~early;
  assign vl_we    = ~early & vl_trunc & (vl_sense == pass);

  assign cand   = {1'b0, srcstep} + (STEP_W+1)'(vl_incl);
  assign vl_val = (cand > {1'b0, vlen}) ? vlen : cand[STEP_W-1:0];
endmodule

// File: rtl/vbr_step_eval.sv
module vbr_step_eval #(
  parameter int CNT_W  = 64,
  parameter int CR_W   = 32,
  parameter int STEP_W = 7,
  localparam int SEL_W = $clog2(CR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        br_ctl,
  input  logic [SEL_W-1:0]  crsel,
  input  logic [CR_W-1:0]   cond_reg,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wide_mode,
  input  logic              pred,
  input  logic              m_mask_eval,
  input  logic              m_subst,
  input  logic              m_ctr_test,
  input  logic              m_ctr_inv,
  input  logic              m_vl_trunc,
  input  logic              m_vl_sense,
  input  logic              m_vl_incl,
  input  logic              m_vlink,
  input  logic              m_link,
  input  logic [STEP_W-1:0] srcstep,
  input  logic [STEP_W-1:0] vlen,
  output logic              out_valid,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              cond_met,
  output logic              vl_we,
  output logic [STEP_W-1:0] vl_val,
  output logic              lr_we,
  output logic              svlr_we,
  output logic              early_done
);
  import vbr_pkg::*;

  vbr_mode_t         mode;
  logic              early, ctr_ok, cond_ok;
  logic [CNT_W-1:0]  cnt_new;
  logic              met_new, vlwe_new, lr_new, svlr_new;
  logic [STEP_W-1:0] vlval_new;

  logic              val_d, val_q;
  logic [CNT_W-1:0]  cnt_d, cnt_q;
  logic              met_d, met_q, vlwe_d, vlwe_q, lr_d, lr_q, svlr_d, svlr_q, early_d, early_q;
  logic [STEP_W-1:0] vlval_d, vlval_q;

  assign mode = '{mask_eval: m_mask_eval, subst: m_subst, ctr_test: m_ctr_test,
                  ctr_inv: m_ctr_inv, vl_trunc: m_vl_trunc, vl_sense: m_vl_sense,
                  vl_incl: m_vl_incl, vlink: m_vlink, link: m_link};

  assign early = ~pred & ~mode.mask_eval;

  vbr_cond_eval #(.CNT_W(CNT_W), .CR_W(CR_W)) u_cond (
    .br_ctl(br_ctl), .crsel(crsel), .cond_reg(cond_reg), .cnt(cnt_i),
    .wide_mode(wide_mode), .pred(pred), .subst_bit(mode.subst),
    .ctr_ok(ctr_ok), .cond_ok(cond_ok)
  );

  vbr_cnt_update #(.CNT_W(CNT_W)) u_cnt (
    .cnt(cnt_i), .ign_ctr(br_ctl[2]), .early(early), .ctr_test(mode.ctr_test),
    .ctr_inv(mode.ctr_inv), .cond_ok(cond_ok), .cnt_nxt(cnt_new)
  );

  vbr_vl_link #(.STEP_W(STEP_W)) u_vl (
    .early(early), .ctr_ok(ctr_ok), .cond_ok(cond_ok), .vl_trunc(mode.vl_trunc),
    .vl_sense(mode.vl_sense), .vl_incl(mode.vl_incl), .vlink(mode.vlink),
    .link(mode.link), .srcstep(srcstep), .vlen(vlen), .cond_met(met_new),
    .vl_we(vlwe_new), .vl_val(vlval_new), .lr_we(lr_new), .svlr_we(svlr_new)
  );

  // next state: results load only under the strobe
  always_comb begin
    val_d   = in_valid;
    cnt_d   = cnt_q;
    met_d   = met_q;
    vlwe_d  = vlwe_q;
    vlval_d = vlval_q;
    lr_d    = lr_q;
    svlr_d  = svlr_q;
    early_d = early_q;
    if (in_valid) begin
      cnt_d   = cnt_new;
      met_d   = met_new;
      vlwe_d  = vlwe_new;
      vlval_d = vlval_new;
      lr_d    = lr_new;
      svlr_d  = svlr_new;
      early_d = early;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= 1'b0;
      cnt_q   <= '0;
      met_q   <= 1'b0;
      vlwe_q  <= 1'b0;
      vlval_q <= '0;
      lr_q    <= 1'b0;
      svlr_q  <= 1'b0;
      early_q <= 1'b0;
    end else begin
      val_q   <= val_d;
      cnt_q   <= cnt_d;
      met_q   <= met_d;
      vlwe_q  <= vlwe_d;
      vlval_q <= vlval_d;
      lr_q    <= lr_d;
      svlr_q  <= svlr_d;
      early_q <= early_d;
    end
  end

  assign out_valid  = val_q;
  assign cnt_o      = cnt_q;
  assign cond_met   = met_q;
  assign vl_we      = vlwe_q;
  assign vl_val     = vlval_q;
  assign lr_we      = lr_q;
  assign svlr_we    = svlr_q;
  assign early_done = early_q;

  p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_early_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && early_done) |-> (!vl_we && !lr_we && !svlr_we && !cond_met));
  p_dec_by_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (cnt_o == $past(cnt_i) || cnt_o == $past(cnt_i) - CNT_W'(1)));
  p_vl_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!vl_we || vl_val <= $past(vlen)));
  p_link_needs_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (lr_we || svlr_we)) |-> cond_met);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(cnt_o) && $stable(vl_val) && $stable(cond_met)));
endmodule

// File: tb/vbr_step_eval_tb.sv
`timescale 1ns/1ps
module vbr_step_eval_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  br_ctl;
  logic [4:0]  crsel;
  logic [31:0] cond_reg;
  logic [63:0] cnt_i;
  logic        wide_mode, pred, m_mask_eval, m_subst, m_ctr_test, m_ctr_inv;
  logic        m_vl_trunc, m_vl_sense, m_vl_incl, m_vlink, m_link;
  logic [6:0]  srcstep, vlen;
  logic        out_valid, cond_met, vl_we, lr_we, svlr_we, early_done;
  logic [63:0] cnt_o;
  logic [6:0]  vl_val;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // expected results
  logic [63:0] e_cnt;
  logic        e_met, e_vlwe, e_lr, e_svlr, e_early;
  logic [6:0]  e_vlval;

  always #2 clk = ~clk;

  vbr_step_eval dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .br_ctl(br_ctl), .crsel(crsel),
    .cond_reg(cond_reg), .cnt_i(cnt_i), .wide_mode(wide_mode), .pred(pred),
    .m_mask_eval(m_mask_eval), .m_subst(m_subst), .m_ctr_test(m_ctr_test),
    .m_ctr_inv(m_ctr_inv), .m_vl_trunc(m_vl_trunc), .m_vl_sense(m_vl_sense),
    .m_vl_incl(m_vl_incl), .m_vlink(m_vlink), .m_link(m_link), .srcstep(srcstep),
    .vlen(vlen), .out_valid(out_valid), .cnt_o(cnt_o), .cond_met(cond_met),
    .vl_we(vl_we), .vl_val(vl_val), .lr_we(lr_we), .svlr_we(svlr_we),
    .early_done(early_done)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected values from the requirements
  task automatic model();
    logic nz, tb, cok, dok, pass, dec;
    logic [7:0] cand;
    nz   = wide_mode ? (cnt_i != 64'd0) : (cnt_i[31:0] != 32'd0);       // R4
    tb   = pred ? cond_reg[31 - crsel] : m_subst;                         // R3
    cok  = br_ctl[2] | (nz ^ br_ctl[3]);
    dok  = br_ctl[0] | (tb == br_ctl[1]);                                 // R5
    pass = cok & dok;
    e_early = !pred && !m_mask_eval;                                      // R6
    if (e_early) dec = !br_ctl[2] && m_ctr_test && !m_ctr_inv;
    else         dec = !br_ctl[2] && !(m_ctr_test && (dok ^ m_ctr_inv));  // R7
    e_cnt  = dec ? cnt_i - 64'd1 : cnt_i;
    e_met  = pass && !e_early;
    e_lr   = m_link && pass && !e_early;                                  // R10
    e_svlr = m_vlink && pass && !e_early;
    e_vlwe = !e_early && m_vl_trunc && (m_vl_sense == pass);              // R8
    cand   = {1'b0, srcstep} + {7'd0, m_vl_incl};
    e_vlval = (cand > {1'b0, vlen}) ? vlen : cand[6:0];                   // R9
  endtask

  task automatic check_outputs();
    chk("R2 out_valid", {63'd0, out_valid}, 64'd1);
    chk(e_early ? "R6 count" : "R7 count", cnt_o, e_cnt);
    chk("R5 cond_met", {63'd0, cond_met}, {63'd0, e_met});
    chk("R8 vl_we", {63'd0, vl_we}, {63'd0, e_vlwe});
    if (e_vlwe) chk("R9 vl_val", {57'd0, vl_val}, {57'd0, e_vlval});
    chk("R10 lr_we", {63'd0, lr_we}, {63'd0, e_lr});
    chk("R10 svlr_we", {63'd0, svlr_we}, {63'd0, e_svlr});
    chk("R6 early_done", {63'd0, early_done}, {63'd0, e_early});
  endtask

  // called at a negedge with inputs set
  task automatic step();
    model();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_outputs();
  endtask

  task automatic rand_inputs();
    int k;
    br_ctl = 4'($urandom); crsel = 5'($urandom); cond_reg = $urandom;
    k = int'($urandom_range(0, 4));
    case (k)
      0: cnt_i = 64'd0;
      1: cnt_i = 64'd1;
      2: cnt_i = 64'h1_0000_0000;
      default: cnt_i = {$urandom, $urandom};
    endcase
    {wide_mode, pred, m_mask_eval, m_subst, m_ctr_test, m_ctr_inv} = 6'($urandom);
    {m_vl_trunc, m_vl_sense, m_vl_incl, m_vlink, m_link} = 5'($urandom);
    vlen = 7'($urandom);
    srcstep = ($urandom_range(0, 3) == 0) ? vlen : 7'($urandom);
  endtask

  task automatic clear_inputs();
    br_ctl = '0; crsel = '0; cond_reg = '0; cnt_i = '0;
    {wide_mode, pred, m_mask_eval, m_subst, m_ctr_test, m_ctr_inv} = '0;
    {m_vl_trunc, m_vl_sense, m_vl_incl, m_vlink, m_link} = '0;
    srcstep = '0; vlen = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0; in_valid = 1'b0; clear_inputs();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R1 cnt_o", cnt_o, 64'd0);
    chk("R1 flags", {58'd0, cond_met, vl_we, lr_we, svlr_we, early_done, 1'b0}, 64'd0);
    chk("R1 vl_val", {57'd0, vl_val}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: bit 32 only set, 32-bit width sees zero, 64-bit sees nonzero
    clear_inputs(); cnt_i = 64'h1_0000_0000; pred = 1'b1; m_link = 1'b1;
    br_ctl = 4'b0001; wide_mode = 1'b0; step();
    wide_mode = 1'b1; step();
    // R7: decrement of zero wraps
    clear_inputs(); pred = 1'b1; br_ctl = 4'b1001; wide_mode = 1'b1; step();
    chk("R7 wrap", cnt_o, 64'hFFFF_FFFF_FFFF_FFFF);
    // R3: predicate clear, substitute decides, register bit opposite
    clear_inputs(); m_mask_eval = 1'b1; pred = 1'b0; cond_reg = 32'h8000_0000;
    crsel = 5'd0; m_subst = 1'b0; br_ctl = 4'b0110; m_link = 1'b1; step();
    pred = 1'b1; step();
    // R6: early finish with each counter-test setting
    clear_inputs(); cnt_i = 64'd5; m_link = 1'b1; m_vl_trunc = 1'b1; br_ctl = 4'b0001;
    m_ctr_test = 1'b1; m_ctr_inv = 1'b0; step();
    m_ctr_inv = 1'b1; step();
    m_ctr_test = 1'b0; step();
    // R9: clamp at vlen
    clear_inputs(); pred = 1'b1; br_ctl = 4'b0101; m_vl_trunc = 1'b1; m_vl_sense = 1'b1;
    m_vl_incl = 1'b1; srcstep = 7'd20; vlen = 7'd20; step();
    chk("R9 clamp", {57'd0, vl_val}, 64'd20);

    for (int i = 0; i < 400; i++) begin
      rand_inputs();
      step();
      if (i % 8 == 0) begin
        // R11: inputs change without strobe, results hold
        rand_inputs();
        @(negedge clk);
        chk("R11 out_valid low", {63'd0, out_valid}, 64'd0);
        chk("R11 cnt hold", cnt_o, e_cnt);
        chk("R11 flags hold", {59'd0, cond_met, vl_we, lr_we, svlr_we, early_done},
            {59'd0, e_met, e_vlwe, e_lr, e_svlr, e_early});
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule